// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block moves outgoing packets from memory to a byte stream. It holds a ring of four descriptor slots. Each slot has three words: a buffer pointer word, a byte count and a completion status. Software prepares a slot in three writes. It clears the status, writes the byte count, then writes the pointer word with the enable bit set and the done bit clear. The engine owns an armed slot until it clears the enable bit. While it owns the slot, it reads the buffer one byte at a time over a simple memory read port. It sends each byte on a ready/valid stream and marks the final byte. When the packet is finished, it writes the completion status, swaps enable for done and moves on to the next slot.

The engine serves the slots strictly in ring order. If the slot under its pointer is not armed, it waits on that slot and does not look at later ones. Done drives the interrupt line. Software clears done by writing the pointer word with the done bit at zero. The pointer field counts up as the buffer is read, so software must write a fresh buffer address each time it re-arms a slot.

The sequencer has five states. IDLE waits on the current slot. FETCH issues one memory read. LOAD captures the returned byte. SEND offers the byte on the stream. FINISH writes the completion and advances the slot pointer.
- IDLE goes to FETCH when the slot is armed with a nonzero count.
- IDLE goes to FINISH when the slot is armed with a zero count.
- FETCH always goes to LOAD, and LOAD always goes to SEND.
- SEND goes back to FETCH when a byte other than the final one is accepted.
- SEND goes to FINISH when the final byte is accepted.
- FINISH always returns to IDLE.

Top module: `txring_dma`

## Requirements
- R1: After reset, every word of every slot reads as zero, and irq, tx_valid and mem_req are low.
- R2: Slots are served strictly in the order 0, 1, 2, 3, 0, and so on. After a slot completes, the next one served is the following slot, wrapping from 3 to 0.
- R3: Word layout, selected by reg_field. Code 0 is the pointer word: bits 23:0 hold the buffer address, bit 30 is enable and bit 31 is done. Code 1 is the byte count in bits 15:0. Code 2 is the status word: bit 0 is sent-OK, bit 1 is empty-packet error and bits 31:16 are the bytes sent. reg_rdata shows the addressed word combinationally, and a byte count written by software reads back unchanged after completion.
- R4: While the slot under the pointer has enable clear, the engine stays idle on it. A later armed slot is not started and keeps enable set.
- R5: Each byte is fetched with exactly one mem_req pulse. mem_rdata is expected one cycle after the pulse. Bytes are read from the armed address upward by one per byte and are sent in that order. While the slot is active, its pointer field shows the next address to read.
- R6: tx_last is high on the byte whose number equals the byte count and on no other byte. While tx_valid is high and tx_ready is low, tx_data and tx_last hold steady.
- R7: On completion, the pointer field reads start address plus count, enable is clear and done is set. The status reads bit 0 set, bit 1 clear and bits 31:16 equal to the count.
- R8: irq is high exactly while some slot has done set. Writing the pointer word with bit 31 at zero clears done. Writing bit 31 at one never sets done.
- R9: Software writes to any word of a slot whose enable is set have no effect.
- R10: A slot armed with a count of zero completes without any stream byte. Its status reads 2 (error bit set, count zero) and done is set.
- R11: A software write to one slot and the engine's completion of another slot in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_slot | input | 2 | Slot index for a write or read |
| reg_field | input | 2 | Word select: 0 pointer, 1 count, 2 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word |
| mem_req | output | 1 | One-byte memory read request |
| mem_addr | output | 24 | Byte address of the request |
| mem_rdata | input | 8 | Byte returned one cycle after mem_req |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream sink ready |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Marks the final byte of a packet |
| irq | output | 1 | High while any slot has done set |

## Verification
The overlap that matters is a software write landing on one slot in the same cycle as the engine's completion write to the slot it is serving. The bench provokes this by writing a changing byte count to an idle slot on every cycle of another slot's transfer. It stops on the first cycle irq is seen high, so its last write falls on the completion edge. The test passes when two things are true afterwards: the idle slot holds the last value written, and the served slot shows a correct status and done.

// File: rtl/txr_pkg.sv
package txr_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_LOAD,
        S_SEND,
        S_FINISH
    } txr_state_e;

    localparam logic [1:0] FLD_PTR  = 2'd0;
    localparam logic [1:0] FLD_CNT  = 2'd1;
    localparam logic [1:0] FLD_STAT = 2'd2;

    localparam int BIT_EN = 30;
    localparam int BIT_DN = 31;

    localparam int STAT_OK      = 0;
    localparam int STAT_EMPTY   = 1;
    localparam int STAT_CNT_LSB = 16;

endpackage

// File: rtl/txr_slot_regs.sv
module txr_slot_regs
    import txr_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int AW    = 24,
    parameter int LW    = 16,
    parameter int SW    = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we,
    input  logic [SW-1:0]     sw_slot,
    input  logic [1:0]        sw_field,
    input  logic [31:0]       sw_wdata,
    output logic [31:0]       rd_data,
    input  logic [SW-1:0]     cur_slot,
    input  logic              addr_inc,
    input  logic              eng_done,
    input  logic [LW-1:0]     eng_count,
    output logic [SLOTS-1:0]  slot_en,
    output logic [SLOTS-1:0]  slot_dn,
    output logic [AW-1:0]     cur_addr,
    output logic [LW-1:0]     cur_len
);

    logic [SLOTS-1:0][AW-1:0] addr_all;
    logic [SLOTS-1:0][LW-1:0] len_all;
    logic [SLOTS-1:0][LW-1:0] scnt_all;
    logic [SLOTS-1:0]         sok_all;
    logic [SLOTS-1:0]         semp_all;

    logic unused_wbits;
    assign unused_wbits = ^sw_wdata[29:AW];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [AW-1:0] a_q;
        logic [LW-1:0] l_q;
        logic [LW-1:0] c_q;
        logic          en_q, dn_q, ok_q, emp_q;
        logic          eng_sel, sw_sel;

        assign eng_sel = (cur_slot == SW'(g));
        assign sw_sel  = sw_we && (sw_slot == SW'(g)) && !en_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                a_q   <= '0;
                l_q   <= '0;
                c_q   <= '0;
                en_q  <= 1'b0;
                dn_q  <= 1'b0;
                ok_q  <= 1'b0;
                emp_q <= 1'b0;
            end else begin
                if (eng_sel && addr_inc) begin
                    a_q <= a_q + 1'b1;
                end
                if (eng_sel && eng_done) begin
                    en_q  <= 1'b0;
                    dn_q  <= 1'b1;
                    ok_q  <= (eng_count != '0);
                    emp_q <= (eng_count == '0);
                    c_q   <= eng_count;
                end
                if (sw_sel) begin
                    unique case (sw_field)
                        FLD_PTR: begin
                            a_q  <= sw_wdata[AW-1:0];
                            en_q <= sw_wdata[BIT_EN];
                            if (!sw_wdata[BIT_DN]) begin
                                dn_q <= 1'b0;
                            end
                        end
                        FLD_CNT: begin
                            l_q <= sw_wdata[LW-1:0];
                        end
                        FLD_STAT: begin
                            ok_q  <= sw_wdata[STAT_OK];
                            emp_q <= sw_wdata[STAT_EMPTY];
                            c_q   <= sw_wdata[STAT_CNT_LSB +: LW];
                        end
                        default: ;
                    endcase
                end
            end
        end

        assign addr_all[g] = a_q;
        assign len_all[g]  = l_q;
        assign scnt_all[g] = c_q;
        assign sok_all[g]  = ok_q;
        assign semp_all[g] = emp_q;
        assign slot_en[g]  = en_q;
        assign slot_dn[g]  = dn_q;
    end

    assign cur_addr = addr_all[cur_slot];
    assign cur_len  = len_all[cur_slot];

    always_comb begin
        rd_data = '0;
        unique case (sw_field)
            FLD_PTR: begin
                rd_data[AW-1:0] = addr_all[sw_slot];
                rd_data[BIT_EN] = slot_en[sw_slot];
                rd_data[BIT_DN] = slot_dn[sw_slot];
            end
            FLD_CNT: begin
                rd_data[LW-1:0] = len_all[sw_slot];
            end
            FLD_STAT: begin
                rd_data[STAT_OK]               = sok_all[sw_slot];
                rd_data[STAT_EMPTY]            = semp_all[sw_slot];
                rd_data[STAT_CNT_LSB +: LW]    = scnt_all[sw_slot];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/txr_fsm.sv
module txr_fsm
    import txr_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int LW    = 16,
    parameter int SW    = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOTS-1:0]  slot_en,
    input  logic [LW-1:0]     cur_len,
    input  logic [7:0]        mem_rdata,
    input  logic              tx_ready,
    output txr_state_e        state,
    output logic [SW-1:0]     cur_slot,
    output logic              addr_inc,
    output logic              eng_done,
    output logic [LW-1:0]     eng_count,
    output logic              mem_req,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last
);

    txr_state_e    nxt;
    logic [SW-1:0] ptr_q;
    logic [LW-1:0] sent_q;
    logic [7:0]    byte_q;
    logic          is_last;

    assign is_last = ({1'b0, sent_q} + 1'b1) == {1'b0, cur_len};

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (slot_en[ptr_q]) begin
                    nxt = (cur_len == '0) ? S_FINISH : S_FETCH;
                end
            end
            S_FETCH:  nxt = S_LOAD;
            S_LOAD:   nxt = S_SEND;
            S_SEND: begin
                if (tx_ready) begin
                    nxt = is_last ? S_FINISH : S_FETCH;
                end
            end
            S_FINISH: nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req  = 1'b0;
        addr_inc = 1'b0;
        tx_valid = 1'b0;
        tx_last  = 1'b0;
        eng_done = 1'b0;
        unique case (state)
            S_IDLE:   ;
            S_FETCH: begin
                mem_req  = 1'b1;
                addr_inc = 1'b1;
            end
            S_LOAD:   ;
            S_SEND: begin
                tx_valid = 1'b1;
                tx_last  = is_last;
            end
            S_FINISH: eng_done = 1'b1;
            default:  ;
        endcase
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            sent_q <= '0;
            byte_q <= '0;
        end else begin
            if (state == S_IDLE) begin
                sent_q <= '0;
            end else if (state == S_SEND && tx_ready) begin
                sent_q <= sent_q + 1'b1;
            end
            if (state == S_LOAD) begin
                byte_q <= mem_rdata;
            end
            if (state == S_FINISH) begin
                ptr_q <= (ptr_q == SW'(SLOTS - 1)) ? '0 : ptr_q + 1'b1;
            end
        end
    end

    assign cur_slot  = ptr_q;
    assign eng_count = sent_q;
    assign tx_data   = byte_q;

endmodule

// File: rtl/txring_dma.sv
module txring_dma
    import txr_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int AW    = 24,
    parameter int LW    = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_we,
    input  logic [$clog2(SLOTS)-1:0]   reg_slot,
    input  logic [1:0]                 reg_field,
    input  logic [31:0]                reg_wdata,
    output logic [31:0]                reg_rdata,
    output logic                       mem_req,
    output logic [AW-1:0]              mem_addr,
    input  logic [7:0]                 mem_rdata,
    output logic                       tx_valid,
    input  logic                       tx_ready,
    output logic [7:0]                 tx_data,
    output logic                       tx_last,
    output logic                       irq
);

    localparam int SW = $clog2(SLOTS);

    txr_state_e     state;
    logic [SW-1:0]  cur_slot;
    logic           addr_inc;
    logic           eng_done;
    logic [LW-1:0]  eng_count;
    logic [SLOTS-1:0] slot_en;
    logic [SLOTS-1:0] slot_dn;
    logic [AW-1:0]  cur_addr;
    logic [LW-1:0]  cur_len;

    txr_slot_regs #(.SLOTS(SLOTS), .AW(AW), .LW(LW), .SW(SW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_we     (reg_we),
        .sw_slot   (reg_slot),
        .sw_field  (reg_field),
        .sw_wdata  (reg_wdata),
        .rd_data   (reg_rdata),
        .cur_slot  (cur_slot),
        .addr_inc  (addr_inc),
        .eng_done  (eng_done),
        .eng_count (eng_count),
        .slot_en   (slot_en),
        .slot_dn   (slot_dn),
        .cur_addr  (cur_addr),
        .cur_len   (cur_len)
    );

    txr_fsm #(.SLOTS(SLOTS), .LW(LW), .SW(SW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_en   (slot_en),
        .cur_len   (cur_len),
        .mem_rdata (mem_rdata),
        .tx_ready  (tx_ready),
        .state     (state),
        .cur_slot  (cur_slot),
        .addr_inc  (addr_inc),
        .eng_done  (eng_done),
        .eng_count (eng_count),
        .mem_req   (mem_req),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_last   (tx_last)
    );

    assign mem_addr = cur_addr;
    assign irq      = |slot_dn;

endmodule

// File: rtl/txr_checker.sv
module txr_checker
    import txr_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int SW    = $clog2(SLOTS)
) (
    input logic             clk,
    input logic             rst_n,
    input txr_state_e       state,
    input logic             mem_req,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic [7:0]       tx_data,
    input logic             tx_last,
    input logic             eng_done,
    input logic [SW-1:0]    cur_slot,
    input logic [SLOTS-1:0] slot_en,
    input logic [SLOTS-1:0] slot_dn,
    input logic             irq
);

    p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> cur_slot == (($past(cur_slot) == SW'(SLOTS - 1)) ? '0 : $past(cur_slot) + 1'b1));

    p_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !slot_en[cur_slot]) |=> (state == S_IDLE && $stable(cur_slot)));

    p_one_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> (!mem_req && !tx_valid));

    p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && tx_valid));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    p_handover_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> (!slot_en[$past(cur_slot)] && slot_dn[$past(cur_slot)]));

    p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(eng_done));

    p_dn_set_only_by_engine_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!eng_done && slot_dn == '0) |=> slot_dn == '0);

endmodule

bind txring_dma txr_checker #(.SLOTS(SLOTS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .mem_req  (mem_req),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data),
    .tx_last  (tx_last),
    .eng_done (eng_done),
    .cur_slot (cur_slot),
    .slot_en  (slot_en),
    .slot_dn  (slot_dn),
    .irq      (irq)
);

// File: tb/txring_dma_test.sv
module txring_dma_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_slot = '0;
    logic [1:0]  reg_field = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [23:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [7:0]  tx_data;
    logic        tx_last;
    logic        irq;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int ready_mode = 1;
    int cap_n = 0;
    logic [7:0] cap_data [256];
    logic       cap_last [256];
    int exp_ptr = 0;

    txring_dma uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_slot(reg_slot),
        .reg_field(reg_field), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_last(tx_last), .irq(irq)
    );

    always #2 clk = ~clk;

    function automatic logic [7:0] mem_byte(logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
    endfunction

    function automatic logic [31:0] exp_status(int len);
        if (len == 0) return 32'h2;
        return (32'(len) << 16) | 32'h1;
    endfunction

    always @(posedge clk) begin
        if (mem_req) mem_rdata <= mem_byte(mem_addr);
    end

    always @(posedge clk) begin
        #1;
        case (ready_mode)
            0: tx_ready = 1'b0;
            1: tx_ready = 1'b1;
            default: tx_ready = ($urandom % 4) != 0;
        endcase
    end

    always @(negedge clk) begin
        if (rst_n && tx_valid && tx_ready) begin
            cap_data[cap_n[7:0]] = tx_data;
            cap_last[cap_n[7:0]] = tx_last;
            cap_n++;
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int slot, input logic [1:0] fld, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_slot = 2'(slot); reg_field = fld; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int slot, input logic [1:0] fld, output logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b0; reg_slot = 2'(slot); reg_field = fld;
        #1 d = reg_rdata;
    endtask

    task automatic arm(input int slot, input logic [23:0] a, input int len);
        wr(slot, 2'd2, 32'h0);
        wr(slot, 2'd1, 32'(len));
        wr(slot, 2'd0, {8'h40, a});
    endtask

    task automatic wait_idle(input int slot);
        logic [31:0] w;
        for (int i = 0; i < 4000; i++) begin
            rd(slot, 2'd0, w);
            if (!w[30]) return;
        end
        chk(0, "R7 slot never completed", slot, 0);
    endtask

    task automatic verify_bytes(input int base, input logic [23:0] a, input int len, input string req);
        for (int i = 0; i < len; i++) begin
            chk(cap_data[(base + i) % 256] == mem_byte(a + 24'(i)), req,
                cap_data[(base + i) % 256], mem_byte(a + 24'(i)));
            chk(cap_last[(base + i) % 256] == (i == len - 1), "R6 last marker",
                cap_last[(base + i) % 256], (i == len - 1));
        end
    endtask

    task automatic xfer(input int slot, input logic [23:0] a, input int len);
        logic [31:0] w;
        cap_n = 0;
        arm(slot, a, len);
        wait_idle(slot);
        chk(cap_n == len, "R5 R10 byte count on stream", cap_n, len);
        verify_bytes(0, a, len, "R5 byte data");
        rd(slot, 2'd0, w);
        chk(w[23:0] == a + 24'(len), "R7 pointer advanced", w[23:0], a + 24'(len));
        chk(w[31:30] == 2'b10, "R7 done set enable clear", w[31:30], 2'b10);
        rd(slot, 2'd2, w);
        chk(w == exp_status(len), "R7 R10 status word", w, exp_status(len));
        rd(slot, 2'd1, w);
        chk(w == 32'(len), "R3 count readback", w, len);
        chk(irq == 1'b1, "R8 irq raised", irq, 1);
        wr(slot, 2'd0, {8'h00, a});
        chk(irq == 1'b0, "R8 irq cleared", irq, 0);
        exp_ptr = (slot + 1) % 4;
    endtask

    initial begin
        logic [31:0] w;
        int v;
        int last_v;
        void'($urandom(32'h00C0FFEE));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int s = 0; s < 4; s++) begin
            for (int f = 0; f < 3; f++) begin
                rd(s, 2'(f), w);
                chk(w == 32'h0, "R1 reset word", w, 0);
            end
        end
        chk(irq == 0 && tx_valid == 0 && mem_req == 0, "R1 outputs idle",
            {irq, tx_valid, mem_req}, 0);

        // R4 stall on unarmed slot 0, then R2 order
        ready_mode = 1;
        cap_n = 0;
        arm(1, 24'h001000, 3);
        repeat (40) @(negedge clk);
        rd(1, 2'd0, w);
        chk(w[30] == 1'b1, "R4 later slot still pending", w[30], 1);
        chk(cap_n == 0, "R4 nothing sent while stalled", cap_n, 0);
        arm(0, 24'h002000, 2);
        wait_idle(1);
        chk(cap_n == 5, "R2 both packets sent", cap_n, 5);
        verify_bytes(0, 24'h002000, 2, "R2 slot 0 served first");
        verify_bytes(2, 24'h001000, 3, "R2 slot 1 served second");
        wr(0, 2'd0, 32'h0);
        wr(1, 2'd0, 32'h0);
        chk(irq == 0, "R8 irq cleared after both", irq, 0);

        // R9 writes to busy slot 2 ignored
        ready_mode = 0;
        cap_n = 0;
        arm(2, 24'h003000, 40);
        repeat (10) @(negedge clk);
        wr(2, 2'd1, 32'd5);
        rd(2, 2'd1, w);
        chk(w == 32'd40, "R9 count write ignored", w, 40);
        wr(2, 2'd0, 32'h0);
        rd(2, 2'd0, w);
        chk(w[30] == 1'b1, "R9 enable write ignored", w[30], 1);
        chk(w[23:0] == 24'h003001, "R5 R9 pointer shows next read", w[23:0], 24'h003001);
        chk(cap_n == 0, "R6 no byte without ready", cap_n, 0);
        ready_mode = 2;
        wait_idle(2);
        chk(cap_n == 40, "R9 full packet sent", cap_n, 40);
        verify_bytes(0, 24'h003000, 40, "R5 long packet data");
        rd(2, 2'd2, w);
        chk(w == exp_status(40), "R7 long status", w, exp_status(40));
        wr(2, 2'd0, 32'h0);

        // R10 zero length on slot 3, then wrap to 0
        xfer(3, 24'h004000, 0);

        // R11 write to slot 3 in the completion cycle of slot 0
        ready_mode = 1;
        cap_n = 0;
        arm(0, 24'h005000, 6);
        v = 100;
        last_v = 0;
        forever begin
            @(negedge clk);
            if (irq) break;
            reg_we = 1'b1; reg_slot = 2'd3; reg_field = 2'd1; reg_wdata = 32'(v);
            last_v = v;
            v++;
        end
        reg_we = 1'b0;
        rd(3, 2'd1, w);
        chk(w == 32'(last_v), "R11 idle slot took last write", w, last_v);
        rd(0, 2'd2, w);
        chk(w == exp_status(6), "R11 completion also recorded", w, exp_status(6));
        rd(0, 2'd0, w);
        chk(w[31:30] == 2'b10, "R11 done on served slot", w[31:30], 2'b10);
        verify_bytes(0, 24'h005000, 6, "R2 wrap to slot 0 data");
        wr(0, 2'd0, 32'h0);
        exp_ptr = 1;

        // R8 writing done=1 does not set it
        wr(3, 2'd0, 32'h8000_0000);
        rd(3, 2'd0, w);
        chk(w[31] == 1'b0 && irq == 1'b0, "R8 done not settable", {w[31], irq}, 0);

        // random traffic
        ready_mode = 2;
        for (int n = 0; n < 24; n++) begin
            int len;
            logic [23:0] a;
            len = (($urandom % 8) == 0) ? 0 : int'($urandom % 20) + 1;
            a = 24'($urandom % 24'hFF0000);
            xfer(exp_ptr, a, len);
        end

        summary();
        $finish;
    end

endmodule